// File: doc/BRIEF.md
# Host Access Wait-State Controller

This block sits between an 8-bit generic microprocessor bus and the core of a scan-bus controller. It decodes host reads and writes to seven registers: command, two configuration registers, a counter, a read port that pops the TDI buffer, a write port that pushes the TDO buffer, and a status register. When an access cannot be served yet, the registered ready output stays low for as long as the access stays pending. It goes high again on the cycle the access takes effect.

Each access is blocked by a rule tied to its register. The rules cover an empty input buffer, a full or resetting output buffer, and a command that is still running. They also cover a write/read credit window that applies only during full-duplex scans with a nonzero retiming delay. A software-reset write to the command register bypasses the busy rule. Hosts without wait-state support can poll the status and command registers, and reads of those registers never stall.

Host protocol: the host drives `host_cs` high together with address, direction and data, and holds them. One clock later `host_rdy` is valid. The access has completed once `host_rdy` is seen high, and read data is then valid. The host then drops `host_cs` for at least one cycle. If the host drops `host_cs` while `host_rdy` is low, the access is abandoned.

Top module: `hwg_top`

## Requirements
- R1: After reset `host_rdy` is 1, `cmd_opcode` is 0, and `tdo_push`, `tdi_pop` and `scan_start` are 0.
- R2: A read of address 4 (TDI port) stalls while `tdi_empty` is 1. It completes with `host_rdata` = `tdi_data` and exactly one `tdi_pop` pulse.
- R3: A write to address 5 (TDO port) stalls while `tdo_full` or `tdo_resetting` is 1. It completes with one `tdo_push` pulse carrying the write data. Ready rises at the first clock edge after the blocking input clears.
- R4: While `cmd_opcode` (command bits 3:0, address 0) is nonzero, writes to address 0 (command), 1 (config A), 2 (config B) and 3 (counter) stall without changing the register. `cmd_done` clears the opcode at one edge, and the stalled write completes at the next edge.
- R5: A command write with bit 7 set never stalls. It leaves `cmd_opcode` at 0 and clears the credit counter.
- R6: When `cmd_opcode` equals 3 (full duplex) and config B bits 2:0 are nonzero, TDO writes may lead TDI reads by at most 5. A sixth outstanding write stalls until a TDI read has been served.
- R7: The credit limit does not apply when the retiming field is 0 or when the opcode is not 3.
- R8: A status read (address 6) returns bit 7 = TDI data available, bit 6 = a TDO write would be accepted, bit 0 = command busy, and all other bits 0. A command read returns the opcode in bits 3:0. Reads of the configuration and counter registers return the last written value. None of these reads stalls.
- R9: Each served access has exactly one side effect. A command write with a nonzero opcode and bit 7 clear gives one `scan_start` pulse.
- R10: An access abandoned while stalled has no side effect, and `host_rdy` returns to 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs | input | 1 | Access request, held until served or abandoned |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid when the access completes |
| host_rdy | output | 1 | Registered ready; low while a pending access is blocked |
| tdi_data | input | 8 | Head of the TDI buffer |
| tdi_empty | input | 1 | TDI buffer holds no data |
| tdo_full | input | 1 | TDO buffer cannot take data |
| tdo_resetting | input | 1 | TDO buffer is being reset at scan start |
| cmd_done | input | 1 | Scan engine finished the current command |
| cmd_opcode | output | 4 | Current command opcode |
| cfg_a | output | 8 | Configuration A |
| cfg_b | output | 8 | Configuration B; bits 2:0 are the retiming delay |
| scan_count | output | 8 | Counter register |
| scan_start | output | 1 | One-cycle pulse when a command is issued |
| tdi_pop | output | 1 | One-cycle pulse when a TDI byte is consumed |
| tdo_push | output | 1 | One-cycle pulse when a TDO byte is written |
| tdo_data | output | 8 | Byte pushed into the TDO buffer |

## Verification
The credit stall is the hardest case to reach. It needs config B to be written while the block is idle, a full-duplex command to be issued, the TDO buffer to be kept not-full, and then five TDO writes with no TDI read in between. Only the sixth write stalls. The stimulus builds this in that order and abandons the stalled write. It then shows that one TDI read lets exactly one more write through. The busy release is driven by raising `cmd_done` while a configuration write is held, and the bench checks that ready rises exactly two edges later.

// File: rtl/hwg_pkg.sv
// Shared types for the host access wait-state controller.
// Assumes an 8-bit host data bus and a 3-bit register address.
package hwg_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CMD  = 3'd0,
        REG_CFGA = 3'd1,
        REG_CFGB = 3'd2,
        REG_CNT  = 3'd3,
        REG_TDI  = 3'd4,
        REG_TDO  = 3'd5,
        REG_STAT = 3'd6,
        REG_NONE = 3'd7
    } hwg_reg_e;

    typedef struct packed {
        logic              we;
        hwg_reg_e          sel;
        logic [DATA_W-1:0] data;
    } hwg_acc_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_HOLD = 2'd2
    } hwg_state_e;
endpackage

// File: rtl/hwg_block_rules.sv
// Combinational decision of whether one host access must be held off.
// Assumes every input is a synchronous level from the current cycle.
module hwg_block_rules
    import hwg_pkg::*;
(
    input  hwg_acc_t acc,
    input  logic     tdi_empty,
    input  logic     tdo_stop,
    input  logic     busy,
    output logic     blocked
);
    // Apply the blocking rule that belongs to the addressed register.
    always_comb begin
        unique case (acc.sel)
            REG_TDI:  blocked = !acc.we && tdi_empty;
            REG_TDO:  blocked = acc.we && tdo_stop;
            REG_CMD:  blocked = acc.we && busy && !acc.data[DATA_W-1];
            REG_CFGA,
            REG_CFGB,
            REG_CNT:  blocked = acc.we && busy;
            default:  blocked = 1'b0;
        endcase
    end
endmodule

// File: rtl/hwg_credit.sv
// Saturating up/down counter of TDO writes not yet matched by TDI reads.
// Assumes inc and dec are never both asserted; counting only while enabled.
module hwg_credit #(
    parameter int LIMIT = 5,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          enable,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] count,
    output logic          at_limit
);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    // Track the lead of writes over reads, clearing at scan start or soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (inc && enable && count < LIM) begin
            count <= count + 1'b1;
        end else if (dec && count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign at_limit = (count == LIM);

    p_credit_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LIM);

    p_credit_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0);
endmodule

// File: rtl/hwg_regs.sv
// Command, configuration and counter registers with opcode-busy tracking.
// Assumes the caller only asserts wr_en for writes that passed the blocking rules.
module hwg_regs
    import hwg_pkg::*;
#(
    parameter int OPC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  hwg_reg_e          wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cmd_done,
    output logic [OPC_W-1:0]  opcode,
    output logic [DATA_W-1:0] cfg_a,
    output logic [DATA_W-1:0] cfg_b,
    output logic [DATA_W-1:0] cnt,
    output logic              scan_start
);
    logic cmd_wr;
    assign cmd_wr = wr_en && (wr_sel == REG_CMD);

    // Update the opcode from command writes and retire it on command completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode     <= '0;
            scan_start <= 1'b0;
        end else begin
            scan_start <= 1'b0;
            if (cmd_wr) begin
                if (wr_data[DATA_W-1]) begin
                    opcode <= '0;
                end else begin
                    opcode     <= wr_data[OPC_W-1:0];
                    scan_start <= (wr_data[OPC_W-1:0] != '0);
                end
            end else if (cmd_done && opcode != '0) begin
                opcode <= '0;
            end
        end
    end

    // Hold the configuration and counter values written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_a <= '0;
            cfg_b <= '0;
            cnt   <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                REG_CFGA: cfg_a <= wr_data;
                REG_CFGB: cfg_b <= wr_data;
                REG_CNT:  cnt   <= wr_data;
                default:  ;
            endcase
        end
    end

    p_cfg_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode != '0) |=> ($stable(cfg_a) && $stable(cfg_b) && $stable(cnt)));

    p_start_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        scan_start |=> !scan_start);
endmodule

// File: rtl/hwg_top.sv
// Host-side access gate: decodes the register map, holds blocked accesses
// with a registered ready and fires each access's side effect exactly once.
// Assumes the host holds cs and its access fields until ready is seen high.
module hwg_top
    import hwg_pkg::*;
#(
    parameter int          OPC_W        = 4,
    parameter logic [3:0]  FD_OPCODE    = 4'h3,
    parameter int          CREDIT_LIMIT = 5,
    parameter int          RETIME_W     = 3,
    localparam int         CW           = $clog2(CREDIT_LIMIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rdy,
    input  logic [DATA_W-1:0] tdi_data,
    input  logic              tdi_empty,
    input  logic              tdo_full,
    input  logic              tdo_resetting,
    input  logic              cmd_done,
    output logic [OPC_W-1:0]  cmd_opcode,
    output logic [DATA_W-1:0] cfg_a,
    output logic [DATA_W-1:0] cfg_b,
    output logic [DATA_W-1:0] scan_count,
    output logic              scan_start,
    output logic              tdi_pop,
    output logic              tdo_push,
    output logic [DATA_W-1:0] tdo_data
);
    hwg_state_e    state;
    hwg_acc_t      pend, port_acc, cur;
    logic          blocked, fire, busy, tdo_stop, credit_on, credit_full;
    logic          credit_at, credit_clr, credit_inc, credit_dec;
    logic [CW-1:0] credit_cnt;
    logic [DATA_W-1:0] rd_mux;

    assign port_acc = '{we: host_we, sel: hwg_reg_e'(host_addr), data: host_wdata};
    assign cur      = (state == ST_IDLE) ? port_acc : pend;
    assign busy     = (cmd_opcode != '0);

    assign credit_on   = (cmd_opcode == FD_OPCODE[OPC_W-1:0]) && (cfg_b[RETIME_W-1:0] != '0);
    assign credit_full = credit_on && credit_at;
    assign tdo_stop    = tdo_full || tdo_resetting || credit_full;

    hwg_block_rules u_rules (
        .acc       (cur),
        .tdi_empty (tdi_empty),
        .tdo_stop  (tdo_stop),
        .busy      (busy),
        .blocked   (blocked)
    );

    assign fire = host_cs && !blocked && (state != ST_HOLD);

    assign credit_inc = fire && cur.we && (cur.sel == REG_TDO);
    assign credit_dec = fire && !cur.we && (cur.sel == REG_TDI);
    assign credit_clr = fire && cur.we && (cur.sel == REG_CMD)
                        && (cur.data[DATA_W-1] || cur.data[OPC_W-1:0] != '0);

    hwg_credit #(.LIMIT(CREDIT_LIMIT)) u_credit (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (credit_clr),
        .enable   (credit_on),
        .inc      (credit_inc),
        .dec      (credit_dec),
        .count    (credit_cnt),
        .at_limit (credit_at)
    );

    hwg_regs #(.OPC_W(OPC_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (fire && cur.we),
        .wr_sel     (cur.sel),
        .wr_data    (cur.data),
        .cmd_done   (cmd_done),
        .opcode     (cmd_opcode),
        .cfg_a      (cfg_a),
        .cfg_b      (cfg_b),
        .cnt        (scan_count),
        .scan_start (scan_start)
    );

    // Select the value returned by a host read of the current access.
    always_comb begin
        rd_mux = '0;
        unique case (cur.sel)
            REG_CMD:  rd_mux = {{(DATA_W-OPC_W){1'b0}}, cmd_opcode};
            REG_CFGA: rd_mux = cfg_a;
            REG_CFGB: rd_mux = cfg_b;
            REG_CNT:  rd_mux = scan_count;
            REG_TDI:  rd_mux = tdi_data;
            REG_STAT: rd_mux = {!tdi_empty, !tdo_stop, {(DATA_W-3){1'b0}}, busy};
            default:  rd_mux = '0;
        endcase
    end

    // Sequence each access through capture, wait and hold, driving ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            host_rdy <= 1'b1;
            pend     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (host_cs) begin
                    pend <= port_acc;
                    if (blocked) begin
                        state    <= ST_WAIT;
                        host_rdy <= 1'b0;
                    end else begin
                        state <= ST_HOLD;
                    end
                end
                ST_WAIT: if (!host_cs) begin
                    state    <= ST_IDLE;
                    host_rdy <= 1'b1;
                end else if (!blocked) begin
                    state    <= ST_HOLD;
                    host_rdy <= 1'b1;
                end
                ST_HOLD: if (!host_cs) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Produce the single side effect of a served access: read data or a buffer strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
            tdi_pop    <= 1'b0;
            tdo_push   <= 1'b0;
            tdo_data   <= '0;
        end else begin
            tdi_pop  <= 1'b0;
            tdo_push <= 1'b0;
            if (fire) begin
                if (cur.we) begin
                    if (cur.sel == REG_TDO) begin
                        tdo_push <= 1'b1;
                        tdo_data <= cur.data;
                    end
                end else begin
                    host_rdata <= rd_mux;
                    tdi_pop    <= (cur.sel == REG_TDI);
                end
            end
        end
    end

    p_pop_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tdi_pop |-> !$past(tdi_empty));

    p_push_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tdo_push |-> (!$past(tdo_full) && !$past(tdo_resetting)));

    p_swrst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && host_cs && host_we && host_addr == REG_CMD
         && host_wdata[DATA_W-1]) |=> (host_rdy && cmd_opcode == '0));

    p_push_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tdo_push || tdi_pop) |=> !(tdo_push || tdi_pop));

    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_rdy && !host_cs) |=> host_rdy);
endmodule

// File: tb/test_hwg_top.sv
`timescale 1ns/1ps
module test_hwg_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       host_cs, host_we;
    logic [2:0] host_addr;
    logic [7:0] host_wdata, host_rdata, tdi_data, tdo_data;
    logic       host_rdy, tdi_empty, tdo_full, tdo_resetting, cmd_done;
    logic [3:0] cmd_opcode;
    logic [7:0] cfg_a, cfg_b, scan_count;
    logic       scan_start, tdi_pop, tdo_push;

    int n_chk = 0, n_fail = 0, push_cnt = 0, pop_cnt = 0, start_cnt = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    hwg_top i_hwg_top (
        .clk(clk), .rst_n(rst_n), .host_cs(host_cs), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rdy(host_rdy), .tdi_data(tdi_data), .tdi_empty(tdi_empty),
        .tdo_full(tdo_full), .tdo_resetting(tdo_resetting), .cmd_done(cmd_done),
        .cmd_opcode(cmd_opcode), .cfg_a(cfg_a), .cfg_b(cfg_b),
        .scan_count(scan_count), .scan_start(scan_start), .tdi_pop(tdi_pop),
        .tdo_push(tdo_push), .tdo_data(tdo_data)
    );

    // Count one-cycle strobes away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tdo_push)   push_cnt++;
            if (tdi_pop)    pop_cnt++;
            if (scan_start) start_cnt++;
        end
    end

    // Fields: we, addr, wdata, tdi_empty, tdo_full, expect stall, expected read data.
    typedef struct packed {
        logic       we;
        logic [2:0] a;
        logic [7:0] d;
        logic       emp;
        logic       full;
        logic       stall;
        logic [7:0] exp;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{1'b0, 3'd6, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00},
        '{1'b0, 3'd6, 8'h00, 1'b0, 1'b0, 1'b0, 8'hC0},
        '{1'b0, 3'd4, 8'h00, 1'b1, 1'b0, 1'b1, 8'h00},
        '{1'b0, 3'd4, 8'h00, 1'b0, 1'b0, 1'b0, 8'h5A},
        '{1'b1, 3'd5, 8'h11, 1'b0, 1'b1, 1'b1, 8'h00},
        '{1'b1, 3'd5, 8'h22, 1'b0, 1'b0, 1'b0, 8'h00},
        '{1'b1, 3'd1, 8'h3C, 1'b0, 1'b0, 1'b0, 8'h00},
        '{1'b0, 3'd1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h3C},
        '{1'b1, 3'd3, 8'h81, 1'b0, 1'b0, 1'b0, 8'h00},
        '{1'b0, 3'd3, 8'h00, 1'b0, 1'b0, 1'b0, 8'h81},
        '{1'b1, 3'd2, 8'h05, 1'b0, 1'b0, 1'b0, 8'h00},
        '{1'b0, 3'd2, 8'h00, 1'b0, 1'b0, 1'b0, 8'h05}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // One host access; abandons it if ready stays low for max_wait cycles.
    task automatic access(input logic we, input logic [2:0] a, input logic [7:0] d,
                          input int max_wait, output logic stalled, output logic [7:0] rd);
        int n;
        @(negedge clk);
        host_cs = 1'b1; host_we = we; host_addr = a; host_wdata = d;
        @(negedge clk);
        n = 0;
        while (!host_rdy && n < max_wait) begin
            @(negedge clk);
            n++;
        end
        stalled = !host_rdy;
        rd = host_rdata;
        host_cs = 1'b0;
        @(negedge clk);
    endtask

    function automatic string req_of(input logic [2:0] a);
        case (a)
            3'd4:    return "R2";
            3'd5:    return "R3";
            default: return "R8";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic       st;
        logic [7:0] rd;
        int         p0, stalls;

        rst_n = 1'b0; host_cs = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
        tdi_data = 8'h5A; tdi_empty = 1'b1; tdo_full = 1'b0; tdo_resetting = 1'b0;
        cmd_done = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 rdy", host_rdy, 1);
        chk("R1 opcode", cmd_opcode, 0);
        chk("R1 strobes", {tdo_push, tdi_pop, scan_start}, 0);
        rst_n = 1'b1;

        // Table of basic accesses.
        for (int i = 0; i < 12; i++) begin
            tdi_empty = VEC[i].emp;
            tdo_full  = VEC[i].full;
            access(VEC[i].we, VEC[i].a, VEC[i].d, 4, st, rd);
            chk({req_of(VEC[i].a), " stall"}, st, VEC[i].stall);
            if (!VEC[i].we && !VEC[i].stall) chk({req_of(VEC[i].a), " rdata"}, rd, VEC[i].exp);
        end
        chk("R10 abandoned no push", push_cnt, 1);
        chk("R10 abandoned no pop", pop_cnt, 1);
        chk("R3 tdo_data", tdo_data, 8'h22);

        // R3: release timing once tdo_full drops; resetting also blocks.
        tdi_empty = 1'b0; tdo_full = 1'b1;
        p0 = push_cnt;
        @(negedge clk);
        host_cs = 1'b1; host_we = 1'b1; host_addr = 3'd5; host_wdata = 8'h99;
        repeat (2) @(negedge clk);
        chk("R3 held", host_rdy, 0);
        tdo_full = 1'b0;
        @(negedge clk);
        chk("R3 release edge", host_rdy, 1);
        host_cs = 1'b0;
        @(negedge clk);
        chk("R9 single push", push_cnt - p0, 1);
        chk("R3 data", tdo_data, 8'h99);
        tdo_resetting = 1'b1;
        access(1'b1, 3'd5, 8'h44, 4, st, rd);
        chk("R3 resetting stall", st, 1);
        tdo_resetting = 1'b0;

        // R4: busy command blocks register writes until done.
        access(1'b1, 3'd0, 8'h01, 4, st, rd);
        chk("R9 scan_start", start_cnt, 1);
        access(1'b0, 3'd6, 8'h00, 4, st, rd);
        chk("R8 status busy", rd, 8'hC1);
        access(1'b0, 3'd0, 8'h00, 4, st, rd);
        chk("R8 cmd read", rd, 8'h01);
        access(1'b1, 3'd1, 8'hFF, 4, st, rd);
        chk("R4 cfg stall", st, 1);
        access(1'b1, 3'd0, 8'h02, 4, st, rd);
        chk("R4 cmd stall", st, 1);
        access(1'b0, 3'd1, 8'h00, 4, st, rd);
        chk("R4 cfg unchanged", rd, 8'h3C);
        @(negedge clk);
        host_cs = 1'b1; host_we = 1'b1; host_addr = 3'd1; host_wdata = 8'h77;
        repeat (3) @(negedge clk);
        chk("R4 held", host_rdy, 0);
        cmd_done = 1'b1;
        @(negedge clk);
        chk("R4 first edge", host_rdy, 0);
        @(negedge clk);
        chk("R4 second edge", host_rdy, 1);
        host_cs = 1'b0; cmd_done = 1'b0;
        @(negedge clk);
        chk("R4 cfg written", cfg_a, 8'h77);

        // R5: soft reset bypasses busy.
        access(1'b1, 3'd0, 8'h01, 4, st, rd);
        access(1'b1, 3'd0, 8'h80, 4, st, rd);
        chk("R5 no stall", st, 0);
        chk("R5 opcode clear", cmd_opcode, 0);

        // R6: credit window under full duplex with retiming.
        access(1'b1, 3'd2, 8'h02, 4, st, rd);
        access(1'b1, 3'd0, 8'h03, 4, st, rd);
        p0 = push_cnt; stalls = 0;
        for (int k = 0; k < 5; k++) begin
            access(1'b1, 3'd5, 8'(k), 4, st, rd);
            stalls += int'(st);
        end
        chk("R6 five accepted", stalls, 0);
        access(1'b0, 3'd6, 8'h00, 4, st, rd);
        chk("R6 status at limit", rd, 8'h81);
        access(1'b1, 3'd5, 8'hA6, 4, st, rd);
        chk("R6 sixth stalls", st, 1);
        access(1'b0, 3'd4, 8'h00, 4, st, rd);
        chk("R6 tdi read", rd, 8'h5A);
        access(1'b1, 3'd5, 8'hA7, 4, st, rd);
        chk("R6 after read", st, 0);
        access(1'b1, 3'd5, 8'hA8, 4, st, rd);
        chk("R6 limit again", st, 1);
        chk("R6 push count", push_cnt - p0, 6);
        access(1'b1, 3'd0, 8'h80, 4, st, rd);
        access(1'b1, 3'd5, 8'hA9, 4, st, rd);
        chk("R5 credit cleared", st, 0);

        // R7: no limit with zero retiming or another opcode.
        access(1'b1, 3'd2, 8'h00, 4, st, rd);
        access(1'b1, 3'd0, 8'h03, 4, st, rd);
        stalls = 0;
        for (int k = 0; k < 7; k++) begin
            access(1'b1, 3'd5, 8'(k), 4, st, rd);
            stalls += int'(st);
        end
        chk("R7 zero retime", stalls, 0);
        access(1'b1, 3'd0, 8'h80, 4, st, rd);
        access(1'b1, 3'd2, 8'h02, 4, st, rd);
        access(1'b1, 3'd0, 8'h01, 4, st, rd);
        stalls = 0;
        for (int k = 0; k < 7; k++) begin
            access(1'b1, 3'd5, 8'(k), 4, st, rd);
            stalls += int'(st);
        end
        chk("R7 other opcode", stalls, 0);
        access(1'b1, 3'd0, 8'h80, 4, st, rd);
        access(1'b0, 3'd6, 8'h00, 4, st, rd);
        chk("R8 status idle", rd, 8'hC0);

        summary();
    end
endmodule